// File: doc/BRIEF.md
# Multiplexed Successive-Approximation Current Search Controller

This block is the digital sequencer for one converter that many remote sensing sites share. A switch array connects one site at a time to a current-steering DAC and a comparator. For the connected site, the controller finds the DAC code whose current brings the site's voltage to the reference. It does this with a binary search that takes one comparator decision per step.

When the search ends, the code is offered to a downstream consumer through a valid/ready handshake. Each result carries the index of the site it came from. Once the consumer accepts the result, the controller selects the next site in round-robin order. It then waits a programmable number of cycles so that the analog path can settle, and starts the next search.

Dropping the enable input stops the scan cleanly. A search that is already running finishes and delivers its result. The controller then rests with the DAC at mid-scale.

Top module: `sar_scan_ctrl`

## Requirements
- R1: While reset is held and right after it is released, dac_code is mid-scale (256 for the default 9-bit code), site_sel is 0 and res_valid is 0.
- R2: The search runs from the most significant bit down. Each trial bit is first set. It is kept when cmp_low is 1 (site voltage below the reference, so more current is needed) and cleared when cmp_low is 0. Suppose the comparator reports 1 exactly when the code is at or below a target T. Then the result is T for every T from 0 to 511.
- R3: Count clock edges from an edge at which the controller is idle and enable is high. The controller spends settle_cycles+1 cycles settling before its first comparator sample. res_valid rises on edge settle_cycles+CODE_W+2.
- R4: Sites are visited in the order 0, 1, ..., SITES-1 and then back to 0. site_sel advances only on the clock edge that completes a result handshake. res_site equals the index of the site that was measured.
- R5: While res_valid is 1 and res_ready is 0, res_code, res_site and site_sel hold their values, and no new search starts.
- R6: Whenever the controller is idle, dac_code is mid-scale. If enable is 0, a running search still completes and delivers its result. The controller then stays idle: res_valid stays 0, dac_code stays at mid-scale and site_sel does not change until enable returns to 1. The scan then resumes at the next site.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows a new search to start from idle |
| settle_cycles | input | SETTLE_W | Extra settling cycles after a site change |
| cmp_low | input | 1 | 1 when the connected site's voltage is below the reference |
| dac_code | output | CODE_W | Code driving the current-steering DAC |
| site_sel | output | SEL_W | Index of the site connected through the switch array |
| res_valid | output | 1 | A result is offered |
| res_ready | input | 1 | The consumer accepts the result |
| res_code | output | CODE_W | Final code of the finished search |
| res_site | output | SEL_W | Site index the result belongs to |

## Verification
The assertions take two things for granted. First, settle_cycles is only changed while the controller is idle. Second, cmp_low is a settled function of the code currently on dac_code, so every decision reflects the trial code shown in that cycle. The bench keeps within both assumptions. It models the comparator combinationally as "dac_code at or below the site's target", and it updates settle_cycles and the target only at the idle point between handshakes. The sweep covers every possible target, several settle lengths and hold times, and a site count that is not a power of two, so the wrap is exercised.

// File: rtl/sar_scan_ctrl.sv
module sar_scan_ctrl #(
  parameter int CODE_W   = 9,
  parameter int SITES    = 4,
  parameter int SETTLE_W = 4,
  localparam int SEL_W   = (SITES > 1) ? $clog2(SITES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                cmp_low,
  output logic [CODE_W-1:0]   dac_code,
  output logic [SEL_W-1:0]    site_sel,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [CODE_W-1:0]   res_code,
  output logic [SEL_W-1:0]    res_site
);

  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_TRIAL, ST_HOLD} state_t;

  state_t              state;
  logic [CODE_W-1:0]   code, mask, kept;
  logic [SETTLE_W-1:0] wait_cnt;
  logic [SEL_W-1:0]    site, site_next;

  assign kept      = cmp_low ? code : (code & ~mask);
  assign site_next = (site == SEL_W'(SITES - 1)) ? '0 : site + SEL_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      code     <= MID;
      mask     <= MID;
      wait_cnt <= '0;
      site     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (enable) begin
          state    <= ST_SETTLE;
          wait_cnt <= settle_cycles;
          mask     <= MID;
          code     <= MID;
        end
        ST_SETTLE: begin
          if (wait_cnt == '0) state <= ST_TRIAL;
          else                wait_cnt <= wait_cnt - SETTLE_W'(1);
        end
        ST_TRIAL: begin
          mask <= mask >> 1;
          if (mask[0]) begin
            code  <= kept;
            state <= ST_HOLD;
          end else begin
            code <= kept | (mask >> 1);
          end
        end
        ST_HOLD: if (res_ready) begin
          state <= ST_IDLE;
          code  <= MID;
          site  <= site_next;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dac_code  = code;
  assign res_code  = code;
  assign site_sel  = site;
  assign res_site  = site;
  assign res_valid = (state == ST_HOLD);

endmodule

// File: rtl/sar_scan_ctrl_chk.sv
module sar_scan_ctrl_chk #(
  parameter int CODE_W   = 9,
  parameter int SITES    = 4,
  parameter int SETTLE_W = 4,
  localparam int SEL_W   = (SITES > 1) ? $clog2(SITES) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic [SETTLE_W-1:0] settle_cycles,
  input logic                cmp_low,
  input logic [CODE_W-1:0]   dac_code,
  input logic [SEL_W-1:0]    site_sel,
  input logic                res_valid,
  input logic                res_ready,
  input logic [CODE_W-1:0]   res_code,
  input logic [SEL_W-1:0]    res_site,
  input logic [1:0]          st
);

  localparam logic [1:0] S_IDLE = 2'd0, S_SETTLE = 2'd1, S_TRIAL = 2'd2;
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic [SETTLE_W:0] gap, cfg_p1;
  logic [SEL_W-1:0]  prev_site, prev_next;
  logic              hs_d;

  assign prev_next = (prev_site == SEL_W'(SITES - 1)) ? '0 : prev_site + SEL_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap       <= '0;
      cfg_p1    <= '0;
      prev_site <= '0;
      hs_d      <= 1'b0;
    end else begin
      if (st == S_SETTLE)    gap <= gap + (SETTLE_W+1)'(1);
      else if (st == S_IDLE) gap <= '0;
      if (st == S_IDLE) cfg_p1 <= (SETTLE_W+1)'(settle_cycles) + (SETTLE_W+1)'(1);
      prev_site <= site_sel;
      hs_d      <= res_valid && res_ready;
    end
  end

  assert_idle_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (dac_code == MID && !res_valid));

  assert_idle_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !enable) |=> (st == S_IDLE));

  assert_keep_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRIAL && cmp_low) |=> (dac_code >= $past(dac_code)));

  assert_clear_lowers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRIAL && !cmp_low) |=> (dac_code < $past(dac_code)));

  assert_settle_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRIAL && $past(st) == S_SETTLE) |-> (gap == cfg_p1));

  assert_hold_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_code) && $stable(res_site)));

  assert_site_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_d |-> (site_sel == prev_next));

  assert_site_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_d |-> (site_sel == prev_site));

endmodule

bind sar_scan_ctrl sar_scan_ctrl_chk #(
  .CODE_W(CODE_W), .SITES(SITES), .SETTLE_W(SETTLE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .settle_cycles(settle_cycles),
  .cmp_low(cmp_low), .dac_code(dac_code), .site_sel(site_sel),
  .res_valid(res_valid), .res_ready(res_ready), .res_code(res_code),
  .res_site(res_site), .st(state)
);

// File: tb/tb_sar_scan_ctrl.sv
module tb_sar_scan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 9;
  localparam int NS = 5;
  localparam int SW = 4;
  localparam int SLW = 3;
  localparam int MIDV = 256;

  logic clk = 1'b0;
  logic rst_n, enable, res_ready, cmp_low, res_valid;
  logic [SW-1:0]  settle;
  logic [CW-1:0]  dac_code, res_code, tgt;
  logic [SLW-1:0] site_sel, res_site;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmp_low = (dac_code <= tgt);

  sar_scan_ctrl #(.CODE_W(CW), .SITES(NS), .SETTLE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .settle_cycles(settle),
    .cmp_low(cmp_low), .dac_code(dac_code), .site_sel(site_sel),
    .res_valid(res_valid), .res_ready(res_ready), .res_code(res_code),
    .res_site(res_site));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valid(inout int lat);
    while (!res_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic handshake();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; res_ready = 1'b0; settle = '0; tgt = '0;
    repeat (3) @(negedge clk);
    check(dac_code == CW'(MIDV), "R1 code in reset", int'(dac_code), MIDV);
    check(res_valid == 1'b0, "R1 valid in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(site_sel == '0, "R1 site after reset", int'(site_sel), 0);
    check(dac_code == CW'(MIDV) && !res_valid, "R1 idle after reset", int'(dac_code), MIDV);
    enable = 1'b1;

    for (int k = 0; k < 512; k++) begin
      int lat, s, hold;
      logic [CW-1:0] held;
      s = (k % 4) * 5;
      hold = k % 3;
      tgt = CW'(k);
      settle = SW'(s);
      check(dac_code == CW'(MIDV), "R6 idle code mid", int'(dac_code), MIDV);
      lat = 0;
      wait_valid(lat);
      check(lat == s + CW + 2, "R3 latency", lat, s + CW + 2);
      check(res_code == CW'(k), "R2 search result", int'(res_code), k);
      check(res_site == SLW'(k % NS), "R4 result site", int'(res_site), k % NS);
      held = res_code;
      if (hold > 0) begin
        repeat (hold) @(negedge clk);
        check(res_valid && res_code == held && site_sel == SLW'(k % NS),
              "R5 result held", int'(res_code), int'(held));
      end
      handshake();
    end

    begin
      int lat;
      bit idle_ok;
      tgt = CW'(300);
      settle = SW'(2);
      lat = 0;
      repeat (3) begin @(negedge clk); lat++; end
      enable = 1'b0;
      wait_valid(lat);
      check(lat == 2 + CW + 2, "R6 finishes after disable latency", lat, 13);
      check(res_code == CW'(300), "R6 finishes after disable code", int'(res_code), 300);
      check(res_site == SLW'(2), "R4 site after sweep", int'(res_site), 2);
      handshake();
      idle_ok = 1'b1;
      for (int i = 0; i < 20; i++) begin
        if (res_valid || dac_code != CW'(MIDV) || site_sel != SLW'(3)) idle_ok = 1'b0;
        @(negedge clk);
      end
      check(idle_ok, "R6 stays idle while disabled", int'(res_valid), 0);
      enable = 1'b1;
      tgt = CW'(511);
      settle = SW'(15);
      lat = 0;
      wait_valid(lat);
      check(lat == 15 + CW + 2, "R3 max settle latency", lat, 26);
      check(res_code == CW'(511), "R2 full-scale result", int'(res_code), 511);
      check(res_site == SLW'(3), "R6 resumes at next site", int'(res_site), 3);
      handshake();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule